// File: doc/BRIEF.md
# Inbound Request Error Classifier

This block inspects one decoded inbound request header at a time, together with the completer's configuration state, and returns one error verdict. The verdict is none, Unsupported Request, Malformed TLP or Poisoned TLP Received. Beside the verdict it returns a flag vector with one bit per error condition. Every bit whose condition held is set, so logging logic can see all the causes while the reported verdict stays single.

The checks cover four conditions. A request may run past the end of the address window it falls in. A memory write may arrive while memory decoding is disabled. A write may carry more payload than the maximum payload size. A poisoned write may target a control register. When several conditions hold, a fixed ranking picks the one reported: Malformed first, then Poisoned, then Unsupported Request. Two configuration inputs move two cases to Unsupported Request. The address-translation field of the header is accepted and has no effect on the result.

Header kind encoding: 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 message with data, 5 vendor-defined message with data. Verdict encoding: 0 none, 1 Unsupported Request, 2 Malformed, 3 Poisoned. Flag bits: bit 0 window overrun, bit 1 write with memory decoding off, bit 2 payload too large, bit 3 poisoned write to a control register.

Top module: `errc_classifier`

## Requirements
- R1: The verdict and the flags are registered. A header presented with `hdr_valid` high at a clock edge produces `verdict_valid` high at the next edge, with its verdict and flags, for one cycle. While `verdict_valid` is low, the verdict is 0 and the flags are 0. Reset clears all three.
- R2: Memory and I/O requests (kinds 0 to 3) whose address lies in the window [`bar_base`, `bar_base` + 2^`bar_size_log2`) and whose end address (`hdr_addr` + 4*`hdr_len_dw` bytes) exceeds the window's end set flag bit 0 and give verdict 1. An end exactly at the window's end is no error. The sum is formed one bit wider than the address, so it cannot wrap at the top of the address space. A request outside the window sets no flag.
- R3: A memory write (kind 1) with `mem_enable` low sets flag bit 1 and gives verdict 1.
- R4: A write carrying data (kinds 1, 3, 4, 5) with `hdr_len_dw` greater than `max_payload_dw` sets flag bit 2. It gives verdict 2 unless R5 applies. A length equal to the limit is no error.
- R5: When `cfg_mps_as_ur` is high and `mem_enable` is low, the payload-too-large condition is reported as verdict 1 instead of 2.
- R6: A poisoned (`hdr_poison` high) write of kind 1, 3 or 4 with `tgt_ctrl` high sets flag bit 3 and gives verdict 3. Vendor-defined messages (kind 5), reads, and targets that are not control registers set no flag for poison.
- R7: When `cfg_poison_as_ur` is high, the poisoned-control condition is reported as verdict 1 instead of 3.
- R8: When several conditions hold, only the highest-ranked class is reported: Malformed over Poisoned over Unsupported Request. All detected conditions still appear in the flags.
- R9: `hdr_at` has no effect on the verdict or the flags for any value.
- R10: A request that meets none of the conditions gives verdict 0 and flags 0 with `verdict_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header fields are valid this cycle |
| hdr_kind | input | 3 | Request kind (encoding above) |
| hdr_addr | input | ADDR_W | Request byte address |
| hdr_len_dw | input | LEN_W | Payload or read length in DW |
| hdr_poison | input | 1 | Poisoned-data bit of the header |
| hdr_at | input | 2 | Address-translation field (ignored) |
| bar_base | input | ADDR_W | Base of the address window |
| bar_size_log2 | input | SZ_W | Log2 of the window size in bytes |
| mem_enable | input | 1 | Memory decoding enabled |
| max_payload_dw | input | LEN_W | Largest allowed payload in DW |
| tgt_ctrl | input | 1 | Request targets a control register |
| cfg_mps_as_ur | input | 1 | Report oversize with decoding off as Unsupported Request |
| cfg_poison_as_ur | input | 1 | Report poisoned control write as Unsupported Request |
| verdict_valid | output | 1 | Verdict strobe, one cycle after the header |
| verdict | output | 2 | Reported error class |
| cond_flags | output | 4 | Every detected condition, one bit each |

## Verification
On every cycle the assertions check the strobe timing and the zero outputs between verdicts. They also check that the verdict is none exactly when no flag is set. A raised oversize or poison flag must map to the class it ranks as, given the configuration inputs of the cycle before. The write-with-decoding-off flag may appear only when memory decoding was off. The exact window-end arithmetic is shown only by the bench's scenarios, including the boundary that ends at the window's end and the window at the top of the address space. The same holds for the kinds excluded from the poison rule, the two reporting options, and the independence from the translation field.

// File: rtl/errc_pkg.sv
package errc_pkg;

    typedef enum logic [2:0] {
        KIND_MRD   = 3'd0,
        KIND_MWR   = 3'd1,
        KIND_IORD  = 3'd2,
        KIND_IOWR  = 3'd3,
        KIND_MSGD  = 3'd4,
        KIND_MSGVD = 3'd5
    } req_kind_e;

    typedef enum logic [1:0] {
        VERD_NONE = 2'd0,
        VERD_UR   = 2'd1,
        VERD_MAL  = 2'd2,
        VERD_PSN  = 2'd3
    } verdict_e;

    localparam int NUM_FLAGS   = 4;
    localparam int FLG_OVERRUN = 0;
    localparam int FLG_MEMDIS  = 1;
    localparam int FLG_OVERSZ  = 2;
    localparam int FLG_PSNCTL  = 3;

    // class slots in descending rank
    localparam int NUM_CLS = 3;
    localparam int CLS_MAL = 0;
    localparam int CLS_PSN = 1;
    localparam int CLS_UR  = 2;

    typedef logic [NUM_FLAGS-1:0] flags_t;
    typedef logic [NUM_CLS-1:0]   cls_t;

    function automatic verdict_e cls_code(input int slot);
        case (slot)
            CLS_MAL: return VERD_MAL;
            CLS_PSN: return VERD_PSN;
            default: return VERD_UR;
        endcase
    endfunction

    function automatic logic kind_has_data(input req_kind_e k);
        return (k == KIND_MWR) || (k == KIND_IOWR) ||
               (k == KIND_MSGD) || (k == KIND_MSGVD);
    endfunction

    function automatic logic kind_hits_window(input req_kind_e k);
        return (k == KIND_MRD) || (k == KIND_MWR) ||
               (k == KIND_IORD) || (k == KIND_IOWR);
    endfunction

    function automatic logic kind_poison_ctl(input req_kind_e k);
        return (k == KIND_MWR) || (k == KIND_IOWR) || (k == KIND_MSGD);
    endfunction

endpackage

// File: rtl/errc_span_check.sv
module errc_span_check
    import errc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 10,
    localparam int SZ_W  = $clog2(ADDR_W + 1),
    localparam int EXT_W = ADDR_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len_dw,
    input  logic [ADDR_W-1:0] base,
    input  logic [SZ_W-1:0]   size_log2,
    output logic              in_window,
    output logic              overrun
);
    logic [EXT_W-1:0] addr_e;
    logic [EXT_W-1:0] base_e;
    logic [EXT_W-1:0] size_e;
    logic [EXT_W-1:0] limit_e;
    logic [EXT_W-1:0] span_e;
    logic [EXT_W-1:0] end_e;

    always_comb begin
        addr_e    = {1'b0, addr};
        base_e    = {1'b0, base};
        size_e    = EXT_W'(1) << size_log2;
        limit_e   = base_e + size_e;
        span_e    = EXT_W'(len_dw) << 2;
        end_e     = addr_e + span_e;
        in_window = (addr_e >= base_e) && (addr_e < limit_e);
        overrun   = in_window && (end_e > limit_e);
    end
endmodule

// File: rtl/errc_cond_detect.sv
module errc_cond_detect
    import errc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 10,
    localparam int SZ_W  = $clog2(ADDR_W + 1)
) (
    input  req_kind_e         kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len_dw,
    input  logic              poison,
    input  logic [ADDR_W-1:0] bar_base,
    input  logic [SZ_W-1:0]   bar_size_log2,
    input  logic              mem_enable,
    input  logic [LEN_W-1:0]  max_payload_dw,
    input  logic              tgt_ctrl,
    input  logic              cfg_mps_as_ur,
    input  logic              cfg_poison_as_ur,
    output flags_t            flags,
    output cls_t              cls
);
    logic win_hit;
    logic win_over;

    errc_span_check #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) i_span (
        .addr      (addr),
        .len_dw    (len_dw),
        .base      (bar_base),
        .size_log2 (bar_size_log2),
        .in_window (win_hit),
        .overrun   (win_over)
    );

    logic oversz_to_ur;

    always_comb begin
        flags              = '0;
        flags[FLG_OVERRUN] = kind_hits_window(kind) && win_over;
        flags[FLG_MEMDIS]  = (kind == KIND_MWR) && !mem_enable;
        flags[FLG_OVERSZ]  = kind_has_data(kind) && (len_dw > max_payload_dw);
        flags[FLG_PSNCTL]  = kind_poison_ctl(kind) && poison && tgt_ctrl;

        oversz_to_ur = cfg_mps_as_ur && !mem_enable;

        cls          = '0;
        cls[CLS_MAL] = flags[FLG_OVERSZ] && !oversz_to_ur;
        cls[CLS_PSN] = flags[FLG_PSNCTL] && !cfg_poison_as_ur;
        cls[CLS_UR]  = flags[FLG_OVERRUN] || flags[FLG_MEMDIS] ||
                       (flags[FLG_OVERSZ] && oversz_to_ur) ||
                       (flags[FLG_PSNCTL] && cfg_poison_as_ur);
    end

    logic unused_hit;
    assign unused_hit = win_hit;
endmodule

// File: rtl/errc_rank_select.sv
module errc_rank_select
    import errc_pkg::*;
(
    input  cls_t     cls,
    output verdict_e verdict
);
    cls_t won;

    genvar g;
    generate
        for (g = 0; g < NUM_CLS; g++) begin : g_rank
            if (g == 0) begin : g_top
                assign won[g] = cls[g];
            end else begin : g_lower
                assign won[g] = cls[g] && !(|cls[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        verdict = VERD_NONE;
        for (int s = 0; s < NUM_CLS; s++) begin
            if (won[s]) verdict = cls_code(s);
        end
    end
endmodule

// File: rtl/errc_classifier.sv
module errc_classifier
    import errc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 10,
    localparam int SZ_W  = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_valid,
    input  logic [2:0]        hdr_kind,
    input  logic [ADDR_W-1:0] hdr_addr,
    input  logic [LEN_W-1:0]  hdr_len_dw,
    input  logic              hdr_poison,
    input  logic [1:0]        hdr_at,
    input  logic [ADDR_W-1:0] bar_base,
    input  logic [SZ_W-1:0]   bar_size_log2,
    input  logic              mem_enable,
    input  logic [LEN_W-1:0]  max_payload_dw,
    input  logic              tgt_ctrl,
    input  logic              cfg_mps_as_ur,
    input  logic              cfg_poison_as_ur,
    output logic              verdict_valid,
    output logic [1:0]        verdict,
    output logic [3:0]        cond_flags
);
    req_kind_e kind;
    flags_t    flags_d;
    cls_t      cls_d;
    verdict_e  verdict_d;
    verdict_e  verdict_q;
    flags_t    flags_q;
    logic      valid_q;

    assign kind = req_kind_e'(hdr_kind);

    errc_cond_detect #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) i_detect (
        .kind             (kind),
        .addr             (hdr_addr),
        .len_dw           (hdr_len_dw),
        .poison           (hdr_poison),
        .bar_base         (bar_base),
        .bar_size_log2    (bar_size_log2),
        .mem_enable       (mem_enable),
        .max_payload_dw   (max_payload_dw),
        .tgt_ctrl         (tgt_ctrl),
        .cfg_mps_as_ur    (cfg_mps_as_ur),
        .cfg_poison_as_ur (cfg_poison_as_ur),
        .flags            (flags_d),
        .cls              (cls_d)
    );

    errc_rank_select i_rank (
        .cls     (cls_d),
        .verdict (verdict_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            verdict_q <= VERD_NONE;
            flags_q   <= '0;
        end else begin
            valid_q   <= hdr_valid;
            verdict_q <= hdr_valid ? verdict_d : VERD_NONE;
            flags_q   <= hdr_valid ? flags_d : '0;
        end
    end

    assign verdict_valid = valid_q;
    assign verdict       = verdict_q;
    assign cond_flags    = flags_q;

    // translation field is accepted but never inspected
    logic unused_at;
    assign unused_at = ^hdr_at;
endmodule

// File: rtl/errc_checker.sv
module errc_checker (
    input logic       clk,
    input logic       rst,
    input logic       hdr_valid,
    input logic       mem_enable,
    input logic       cfg_mps_as_ur,
    input logic       cfg_poison_as_ur,
    input logic       verdict_valid,
    input logic [1:0] verdict,
    input logic [3:0] cond_flags
);
    assert_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> verdict_valid);

    assert_nostrobe_R1: assert property (@(posedge clk) disable iff (rst)
        !hdr_valid |=> !verdict_valid);

    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (rst)
        !verdict_valid |-> (verdict == 2'd0) && (cond_flags == 4'd0));

    assert_clean_R10: assert property (@(posedge clk) disable iff (rst)
        verdict_valid && (cond_flags == 4'd0) |-> verdict == 2'd0);

    assert_flagged_R8: assert property (@(posedge clk) disable iff (rst)
        verdict_valid && (cond_flags != 4'd0) |-> verdict != 2'd0);

    assert_memdis_R3: assert property (@(posedge clk) disable iff (rst)
        verdict_valid && cond_flags[1] |-> !$past(mem_enable));

    assert_oversize_R4: assert property (@(posedge clk) disable iff (rst)
        verdict_valid && cond_flags[2] &&
        ($past(mem_enable) || !$past(cfg_mps_as_ur)) |-> verdict == 2'd2);

    assert_poison_R6: assert property (@(posedge clk) disable iff (rst)
        verdict_valid && cond_flags[3] && !cond_flags[2] &&
        !$past(cfg_poison_as_ur) |-> verdict == 2'd3);
endmodule

bind errc_classifier errc_checker i_errc_checker (
    .clk              (clk),
    .rst              (rst),
    .hdr_valid        (hdr_valid),
    .mem_enable       (mem_enable),
    .cfg_mps_as_ur    (cfg_mps_as_ur),
    .cfg_poison_as_ur (cfg_poison_as_ur),
    .verdict_valid    (verdict_valid),
    .verdict          (verdict),
    .cond_flags       (cond_flags)
);

// File: tb/test_errc_classifier.sv
module test_errc_classifier;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 10;
    localparam int SZ_W   = $clog2(ADDR_W + 1);

    logic              clk = 1'b0;
    logic              rst;
    logic              hdr_valid;
    logic [2:0]        hdr_kind;
    logic [ADDR_W-1:0] hdr_addr;
    logic [LEN_W-1:0]  hdr_len_dw;
    logic              hdr_poison;
    logic [1:0]        hdr_at;
    logic [ADDR_W-1:0] bar_base;
    logic [SZ_W-1:0]   bar_size_log2;
    logic              mem_enable;
    logic [LEN_W-1:0]  max_payload_dw;
    logic              tgt_ctrl;
    logic              cfg_mps_as_ur;
    logic              cfg_poison_as_ur;
    logic              verdict_valid;
    logic [1:0]        verdict;
    logic [3:0]        cond_flags;

    always #5 clk = ~clk;

    errc_classifier #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_errc_classifier (
        .clk (clk), .rst (rst), .hdr_valid (hdr_valid), .hdr_kind (hdr_kind),
        .hdr_addr (hdr_addr), .hdr_len_dw (hdr_len_dw), .hdr_poison (hdr_poison),
        .hdr_at (hdr_at), .bar_base (bar_base), .bar_size_log2 (bar_size_log2),
        .mem_enable (mem_enable), .max_payload_dw (max_payload_dw),
        .tgt_ctrl (tgt_ctrl), .cfg_mps_as_ur (cfg_mps_as_ur),
        .cfg_poison_as_ur (cfg_poison_as_ur), .verdict_valid (verdict_valid),
        .verdict (verdict), .cond_flags (cond_flags)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  kind;
        logic [31:0] base;
        logic [31:0] addr;
        logic [9:0]  len;
        logic        poison;
        logic [1:0]  at;
        logic        mse;
        logic        ctrl;
        logic        mps_ur;
        logic        psn_ur;
        logic [1:0]  exp_v;
        logic [3:0]  exp_f;
    } vec_t;

    localparam int NV = 27;
    // kinds: 0 MRD 1 MWR 2 IORD 3 IOWR 4 MSGD 5 MSGVD; window 4 KB; max payload 32 DW
    localparam vec_t VECS [NV] = '{
        '{4'd10, 3'd0, 32'h1000_0000, 32'h1000_0000, 10'd4,  1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000}, // R10 clean read
        '{4'd2,  3'd1, 32'h1000_0000, 32'h1000_0FF0, 10'd4,  1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000}, // R2 ends at limit
        '{4'd2,  3'd1, 32'h1000_0000, 32'h1000_0FF0, 10'd5,  1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 4'b0001}, // R2 one DW past
        '{4'd2,  3'd0, 32'h1000_0000, 32'h1000_0FFC, 10'd2,  1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 4'b0001}, // R2 read overrun
        '{4'd2,  3'd2, 32'h1000_0000, 32'h1000_0FFC, 10'd2,  1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 4'b0001}, // R2 I/O read overrun
        '{4'd2,  3'd0, 32'h1000_0000, 32'h2000_0000, 10'd1000,1'b0,2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000}, // R2 outside window
        '{4'd2,  3'd0, 32'hFFFF_F000, 32'hFFFF_FFFC, 10'd2,  1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 4'b0001}, // R2 top, no wrap
        '{4'd2,  3'd0, 32'hFFFF_F000, 32'hFFFF_FFF8, 10'd2,  1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000}, // R2 top, exact end
        '{4'd3,  3'd1, 32'h1000_0000, 32'h1000_0010, 10'd1,  1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 4'b0010}, // R3
        '{4'd4,  3'd1, 32'h1000_0000, 32'h1000_0000, 10'd32, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000}, // R4 at limit
        '{4'd4,  3'd1, 32'h1000_0000, 32'h1000_0000, 10'd33, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 4'b0100}, // R4
        '{4'd4,  3'd1, 32'h1000_0000, 32'h1000_0000, 10'd33, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 4'b0110}, // R4 decoding off
        '{4'd5,  3'd1, 32'h1000_0000, 32'h1000_0000, 10'd33, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 4'b0110}, // R5
        '{4'd5,  3'd1, 32'h1000_0000, 32'h1000_0000, 10'd33, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 4'b0100}, // R5 needs decoding off
        '{4'd4,  3'd4, 32'h1000_0000, 32'h0000_0000, 10'd33, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 4'b0100}, // R4 message
        '{4'd6,  3'd3, 32'h1000_0000, 32'h1000_0020, 10'd1,  1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 4'b1000}, // R6 I/O write
        '{4'd6,  3'd5, 32'h1000_0000, 32'h0000_0000, 10'd1,  1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 4'b0000}, // R6 vendor msg
        '{4'd6,  3'd4, 32'h1000_0000, 32'h0000_0000, 10'd1,  1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 4'b1000}, // R6 message
        '{4'd6,  3'd0, 32'h1000_0000, 32'h1000_0000, 10'd1,  1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 4'b0000}, // R6 read
        '{4'd6,  3'd1, 32'h1000_0000, 32'h1000_0000, 10'd1,  1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000}, // R6 not control
        '{4'd7,  3'd3, 32'h1000_0000, 32'h1000_0000, 10'd1,  1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 4'b1000}, // R7
        '{4'd8,  3'd1, 32'h1000_0000, 32'h1000_0000, 10'd33, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 4'b1100}, // R8 mal>psn
        '{4'd8,  3'd1, 32'h1000_0000, 32'h1000_0000, 10'd1,  1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 4'b1010}, // R8 psn>ur
        '{4'd8,  3'd1, 32'h1000_0000, 32'h1000_0FFC, 10'd2,  1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 4'b1001}, // R8 psn>overrun
        '{4'd9,  3'd0, 32'h1000_0000, 32'h1000_0000, 10'd4,  1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000}, // R9
        '{4'd9,  3'd1, 32'h1000_0000, 32'h1000_0FF0, 10'd5,  1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 4'b0001}, // R9
        '{4'd8,  3'd1, 32'h1000_0000, 32'h1000_0000, 10'd33, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 4'b1110}  // R8 all to UR
    };

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    task automatic check(input string tag, input logic v_act, input logic [1:0] d_act,
                         input logic [3:0] f_act, input logic v_exp,
                         input logic [1:0] d_exp, input logic [3:0] f_exp);
        checks++;
        if (v_act !== v_exp || d_act !== d_exp || f_act !== f_exp) begin
            errors++;
            $display("FAIL %s: valid/verdict/flags actual %b/%0d/%b expected %b/%0d/%b",
                     tag, v_act, d_act, f_act, v_exp, d_exp, f_exp);
        end
    endtask

    task automatic drive(input vec_t v);
        hdr_kind         = v.kind;
        bar_base         = v.base;
        hdr_addr         = v.addr;
        hdr_len_dw       = v.len;
        hdr_poison       = v.poison;
        hdr_at           = v.at;
        mem_enable       = v.mse;
        tgt_ctrl         = v.ctrl;
        cfg_mps_as_ur    = v.mps_ur;
        cfg_poison_as_ur = v.psn_ur;
        hdr_valid        = 1'b1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        hdr_valid = 1'b0;
        drive(VECS[0]);
        hdr_valid      = 1'b0;
        bar_size_log2  = SZ_W'(12);
        max_payload_dw = LEN_W'(32);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", verdict_valid, verdict, cond_flags, 1'b0, 2'd0, 4'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            hdr_valid = 1'b0;
            check($sformatf("R%0d vector %0d", VECS[i].req, i), verdict_valid, verdict,
                  cond_flags, 1'b1, VECS[i].exp_v, VECS[i].exp_f);
        end

        // R1: idle cycle after a flagged request clears the outputs
        drive(VECS[2]);
        @(negedge clk);
        hdr_valid = 1'b0;
        @(negedge clk);
        check("R1 idle after verdict", verdict_valid, verdict, cond_flags, 1'b0, 2'd0, 4'd0);

        // R1: back-to-back headers each get their own verdict
        drive(VECS[10]);
        @(negedge clk);
        check("R1 back-to-back first", verdict_valid, verdict, cond_flags, 1'b1, 2'd2, 4'b0100);
        drive(VECS[15]);
        @(negedge clk);
        hdr_valid = 1'b0;
        check("R1 back-to-back second", verdict_valid, verdict, cond_flags, 1'b1, 2'd3, 4'b1000);

        // R1: reset at the capturing edge wins over a pending header
        drive(VECS[8]);
        rst = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
        rst = 1'b0;
        check("R1 reset over header", verdict_valid, verdict, cond_flags, 1'b0, 2'd0, 4'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule